// File: doc/BRIEF.md
# Event-Driven FIR Filter with Travelling Timing Pulses

This block is an N-tap FIR filter that does its work only when an input sample arrives, not on every cycle. Each accepted sample is written into the first tap. At the same moment a one-cycle ready pulse is launched into a timing path made of N equal segments. Every segment is TD fast-clock cycles long. When a pulse reaches the end of a segment, the sample held in that tap moves into the next tap and the tap it left is cleared. Each such event, and each accepted input, triggers one evaluation of the full convolution sum over all taps. That result is presented for a single cycle.

Samples normally come from an event source such as a level-crossing converter. A sample that arrives fewer than TD cycles after the previously accepted one would break the equal-spacing rule, so it is discarded and flagged. Once the last pulse has left the final segment, no register in the datapath toggles until the next accepted input. With inputs spaced exactly TD apart, the outputs equal those of a conventional clocked FIR. Coefficients are loaded through a simple write port.

Top module: `evt_fir`

## Requirements
- R1: While rst_n is low and in the cycle after it is released, out_valid and in_drop are 0 and out_data is 0. All taps are cleared, so the first output after reset depends only on the first sample.
- R2: An input with in_valid=1 that is accepted is written into tap 0. In the next cycle out_valid=1 and out_data is the sum over k of coef[k]·tap[k], including the new sample.
- R3: A single accepted sample x with no later input gives NTAPS+1 outputs spaced exactly TD cycles apart. Output k (k=0..NTAPS-1) equals coef[k]·x, and the last output equals 0 because the sample has left the filter.
- R4: An input that arrives fewer than TD cycles after the last accepted input is dropped. In the next cycle in_drop=1, no output is produced, and no tap changes. An input exactly TD cycles later is accepted.
- R5: Inputs spaced exactly TD cycles apart give the conventional convolution sum over k=0..NTAPS-1 of coef[k]·x(n-k), with zero for samples before the first.
- R6: When an input and one or more segment-end events, or several segment-end events, fall in the same cycle, exactly one output is produced. That output reflects every move together. A tap being written and read in that same cycle passes its old value on and takes the entering one.
- R7: Outputs stop when the last pulse exits. With no event in a cycle, out_valid is 0 next cycle and out_data keeps its value.
- R8: A write with coef_we=1 sets coefficient coef_addr (tap index 0..NTAPS-1, signed coef_wdata) at the clock edge. The write produces no output itself, and every later output uses the new value.
- R9: out_data is signed two's complement of width DW+CW+ceil(log2 NTAPS), is not rounded, and holds the full sum even with every tap and coefficient at the most negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that times the pulse segments |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Input sample event strobe |
| in_data | input | DW | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | AW | Tap index of the coefficient to write |
| coef_wdata | input | CW | Signed coefficient value |
| out_valid | output | 1 | One-cycle strobe marking a new convolution result |
| out_data | output | DW+CW+ceil(log2 NTAPS) | Full-precision signed convolution result |
| in_drop | output | 1 | One-cycle flag for an input rejected for arriving too early |

## Verification
A pulse that is lost, duplicated or shifted in the timing chain shows at the ports within one segment time. An out_valid strobe then appears in the wrong cycle, or is missing, compared with a model that tracks each sample's age. A wrong tap value, a missed clear of a vacated tap, or a swapped priority between write and move gives a wrong out_data on the very next output strobe. A guard that miscounts the spacing shows up as a wrong in_drop in the cycle after the offending input. The bench compares every cycle, so each of these faults is reported within one cycle of the first observable event.

// File: rtl/fir_evt_pkg.sv
package fir_evt_pkg;
  function automatic int acc_width(input int dw, input int cw, input int ntaps);
    return dw + cw + $clog2(ntaps);
  endfunction
  function automatic int addr_width(input int ntaps);
    return (ntaps > 1) ? $clog2(ntaps) : 1;
  endfunction
endpackage

// File: rtl/evt_gap_guard.sv
module evt_gap_guard #(
  parameter int TD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic accept,
  output logic drop_q
);
  localparam int HW = $clog2(TD + 1);

  logic [HW-1:0] hold_q, hold_d;
  logic          hold_en, drop_d, drop_en;

  always_comb begin
    accept  = in_valid && (hold_q == '0);
    drop_d  = in_valid && !accept;
    drop_en = drop_d || drop_q;
    hold_en = accept || (hold_q != '0);
    if (accept) hold_d = HW'(TD - 1);
    else if (hold_q != '0) hold_d = hold_q - HW'(1);
    else hold_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      drop_q <= 1'b0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      if (drop_en) drop_q <= drop_d;
    end
  end
endmodule

// File: rtl/evt_pulse_chain.sv
module evt_pulse_chain #(
  parameter int NTAPS = 4,
  parameter int TD    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inject,
  output logic [NTAPS*TD-1:0]      chain_q,
  output logic [NTAPS-1:0]         bnd
);
  localparam int LEN = NTAPS * TD;

  logic [LEN-1:0] chain_d;
  logic           chain_en;

  generate
    if (LEN > 1) begin : g_long
      assign chain_d = {chain_q[LEN-2:0], inject};
    end else begin : g_short
      assign chain_d = inject;
    end
    for (genvar k = 0; k < NTAPS; k++) begin : g_bnd
      assign bnd[k] = chain_q[(k+1)*TD-1];
    end
  endgenerate

  assign chain_en = inject || (|chain_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else if (chain_en) chain_q <= chain_d;
  end
endmodule

// File: rtl/evt_tap_store.sv
module evt_tap_store #(
  parameter int NTAPS = 4,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [DW-1:0]              wdata,
  input  logic [NTAPS-1:0]           bnd,
  output logic [NTAPS-1:0][DW-1:0]   taps_d,
  output logic [NTAPS-1:0][DW-1:0]   taps_q
);
  logic taps_en;

  generate
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      if (k == 0) begin : g_head
        always_comb begin
          if (wr) taps_d[k] = wdata;
          else if (bnd[k]) taps_d[k] = '0;
          else taps_d[k] = taps_q[k];
        end
      end else begin : g_body
        always_comb begin
          if (bnd[k-1]) taps_d[k] = taps_q[k-1];
          else if (bnd[k]) taps_d[k] = '0;
          else taps_d[k] = taps_q[k];
        end
      end
    end
  endgenerate

  assign taps_en = wr || (|bnd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps_q <= '0;
    else if (taps_en) taps_q <= taps_d;
  end
endmodule

// File: rtl/evt_mac.sv
module evt_mac #(
  parameter int NTAPS = 4,
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int ACCW  = 18
) (
  input  logic [NTAPS-1:0][DW-1:0] taps,
  input  logic [NTAPS-1:0][CW-1:0] coefs,
  output logic signed [ACCW-1:0]   sum
);
  always_comb begin
    sum = '0;
    for (int k = 0; k < NTAPS; k++) begin
      sum = sum + (ACCW'($signed(taps[k])) * ACCW'($signed(coefs[k])));
    end
  end
endmodule

// File: rtl/evt_fir.sv
module evt_fir
  import fir_evt_pkg::*;
#(
  parameter int NTAPS = 4,
  parameter int TD    = 3,
  parameter int DW    = 8,
  parameter int CW    = 8,
  localparam int ACCW = acc_width(DW, CW, NTAPS),
  localparam int AW   = addr_width(NTAPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  input  logic            coef_we,
  input  logic [AW-1:0]   coef_addr,
  input  logic [CW-1:0]   coef_wdata,
  output logic            out_valid,
  output logic [ACCW-1:0] out_data,
  output logic            in_drop
);
  logic                       accept;
  logic [NTAPS*TD-1:0]        chain_q;
  logic [NTAPS-1:0]           bnd;
  logic [NTAPS-1:0][DW-1:0]   taps_d, taps_q;
  logic [NTAPS-1:0][CW-1:0]   coef_q;
  logic signed [ACCW-1:0]     sum;
  logic                       evt;

  evt_gap_guard #(.TD(TD)) guard_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .accept(accept), .drop_q(in_drop)
  );

  evt_pulse_chain #(.NTAPS(NTAPS), .TD(TD)) chain_i (
    .clk(clk), .rst_n(rst_n), .inject(accept),
    .chain_q(chain_q), .bnd(bnd)
  );

  evt_tap_store #(.NTAPS(NTAPS), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n), .wr(accept), .wdata(in_data),
    .bnd(bnd), .taps_d(taps_d), .taps_q(taps_q)
  );

  evt_mac #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .ACCW(ACCW)) mac_i (
    .taps(taps_d), .coefs(coef_q), .sum(sum)
  );

  generate
    for (genvar k = 0; k < NTAPS; k++) begin : g_coef
      logic we_k;
      assign we_k = coef_we && (coef_addr == AW'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) coef_q[k] <= '0;
        else if (we_k) coef_q[k] <= coef_wdata;
      end
    end
  endgenerate

  assign evt = accept || (|bnd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (evt || out_valid) out_valid <= evt;
      if (evt) out_data <= sum;
    end
  end
endmodule

// File: rtl/evt_fir_chk.sv
module evt_fir_chk #(
  parameter int NTAPS = 4,
  parameter int TD    = 3,
  parameter int ACCW  = 18
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_drop,
  input logic                out_valid,
  input logic [ACCW-1:0]     out_data,
  input logic [NTAPS*TD-1:0] chain,
  input logic [NTAPS-1:0]    bnd
);
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !(|bnd)) |=> !out_valid) else $error("idle cycle produced output"); // R7

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)) else $error("result moved without strobe"); // R7

  AST_DROP_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_drop |-> ($past(in_valid) && !out_valid) || $past(|bnd)) else $error("drop without input"); // R4

  AST_BOUNDARY_GIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (|bnd) |=> out_valid) else $error("segment end without output"); // R6

  generate
    for (genvar s = 0; s < NTAPS; s++) begin : g_seg
      AST_ONE_PULSE_PER_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chain[s*TD +: TD])) else $error("two pulses in one segment"); // R4
    end
  endgenerate
endmodule

bind evt_fir evt_fir_chk #(.NTAPS(NTAPS), .TD(TD), .ACCW(ACCW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_drop(in_drop),
  .out_valid(out_valid), .out_data(out_data), .chain(chain_q), .bnd(bnd)
);

// File: tb/evt_fir_tb_top.sv
`timescale 1ns/1ps
module evt_fir_tb_top;
  localparam int NT   = 4;
  localparam int TD   = 3;
  localparam int DW   = 8;
  localparam int CW   = 8;
  localparam int ACCW = DW + CW + $clog2(NT);
  localparam int AW   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [DW-1:0]   in_data = '0;
  logic            coef_we = 1'b0;
  logic [AW-1:0]   coef_addr = '0;
  logic [CW-1:0]   coef_wdata = '0;
  logic            out_valid;
  logic [ACCW-1:0] out_data;
  logic            in_drop;

  always #2.5 clk = ~clk;

  evt_fir #(.NTAPS(NT), .TD(TD), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .out_valid(out_valid), .out_data(out_data), .in_drop(in_drop)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";

  // Behavioural reference: each sample carries its age in cycles.
  int m_val[$];
  int m_age[$];
  int m_coef[NT];
  int since = TD;
  int exp_v = 0, exp_drop = 0, exp_data = 0;
  int sum;
  bit acc, ev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_val.delete(); m_age.delete();
      for (int k = 0; k < NT; k++) m_coef[k] = 0;
      since = TD; exp_v = 0; exp_drop = 0; exp_data = 0;
    end else begin
      acc = in_valid && (since >= TD);
      ev  = acc;
      foreach (m_age[i])
        if (m_age[i] > 0 && m_age[i] % TD == 0 && m_age[i] <= NT*TD) ev = 1;
      if (acc) begin
        m_val.push_back($signed(in_data));
        m_age.push_back(0);
      end
      if (ev) begin
        sum = 0;
        foreach (m_age[i])
          if (m_age[i] / TD < NT) sum += m_coef[m_age[i] / TD] * m_val[i];
        exp_data = sum;
      end
      exp_v    = ev ? 1 : 0;
      exp_drop = (in_valid && !acc) ? 1 : 0;
      if (coef_we) m_coef[coef_addr] = $signed(coef_wdata);
      since = acc ? 1 : ((since < 1000) ? since + 1 : since);
      foreach (m_age[i]) m_age[i]++;
      while (m_age.size() > 0 && m_age[0] > NT*TD) begin
        void'(m_age.pop_front());
        void'(m_val.pop_front());
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cmp("out_valid", int'(out_valid), exp_v);
    cmp("out_data", int'($signed(out_data)), exp_data);
    cmp("in_drop", int'(in_drop), exp_drop);
  end

  task automatic step(bit v, int d);
    @(negedge clk);
    in_valid = v; in_data = DW'(d); coef_we = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  task automatic wcoef(int a, int w);
    @(negedge clk);
    in_valid = 1'b0; coef_we = 1'b1; coef_addr = AW'(a); coef_wdata = CW'(w);
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    cmp("reset out_valid", int'(out_valid), 0);
    cmp("reset out_data", int'(out_data), 0);
    rst_n = 1'b1;
    idle(2);
    // R8: coefficient load produces no output
    tag = "R8";
    wcoef(0, 3); wcoef(1, -5); wcoef(2, 7); wcoef(3, 2);
    idle(2);
    // R2 then R3: single sample impulse response
    tag = "R2";
    step(1, 10);
    tag = "R3";
    idle(14);
    tag = "R7";
    idle(10);
    // R4: too-early input dropped, exactly TD later accepted
    tag = "R4";
    step(1, 5); step(1, 9); step(0, 0); step(1, -4);
    idle(16);
    // R5: equally spaced stream
    tag = "R5";
    for (int i = 0; i < 8; i++) begin
      step(1, i*7 - 20);
      idle(TD - 1);
    end
    idle(16);
    // R6: irregular spacing with coincident events
    tag = "R6";
    step(1, 11); idle(3); step(1, -6); idle(4); step(1, 100); idle(2);
    step(1, 1); step(1, 50); idle(1); step(1, 60);
    idle(16);
    // R8: coefficient change while a sample is in flight
    tag = "R8";
    step(1, 20); idle(1); wcoef(1, -9);
    idle(14);
    // R9: full-scale negative sum
    tag = "R9";
    for (int k = 0; k < NT; k++) wcoef(k, -128);
    for (int i = 0; i < NT; i++) begin
      step(1, -128);
      idle(TD - 1);
    end
    idle(16);
    tag = "R7";
    idle(8);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog %s actual=timeout expected=finish", tag);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule